// File: doc/BRIEF.md
# Serial Register-Access Slave with Burst Addressing

This block lets an external serial master read and write a 16K-byte register space over a four-wire serial link. The block runs on a system clock. It samples the serial clock, chip select and serial input as synchronous inputs and detects the serial clock edges internally. Each transaction starts with a 16-bit control word that selects read or write, a 14-bit register address, and single-byte or burst operation. Data bytes follow the control word. On the register side the block drives a simple parallel bus: an address, write data, one-cycle write and read strobes, and a read-data input that the register file returns one clock after the read strobe.

In burst mode the address advances after every byte and wraps from the top of the space to zero. In reads the block fetches the next byte one byte ahead, so the serial stream has no gaps. The serial output enable is asserted only while read data is being shifted out. An external buffer can therefore share one data wire between both directions. A static input selects MSB-first or LSB-first bit order.

Top module: `spi_reg_slave`

## Requirements
- R1: The control word is 16 bits, taken on 16 rising serial-clock edges while chip select is low. Its first bit is the direction (1 = read, 0 = write). The next 14 bits are the address, and the last bit is the burst flag (1 = burst, 0 = single byte). With MSB-first order the address arrives A13 down to A0.
- R2: When `lsb_first` is high, the address field arrives A0 up to A13, and every data byte in either direction travels bit 0 first. The direction and burst bits keep their positions.
- R3: A single-byte write produces exactly one `reg_wr` pulse, carrying the decoded address and the first data byte. Any further bytes clocked in before chip select rises produce no write.
- R4: A single-byte read produces one `reg_rd` pulse at the decoded address. The first data bit is driven on the falling serial-clock edge after the 16th control bit. The falling edge after the eighth data bit releases the output enable.
- R5: A burst write writes each completed data byte to the current address and then advances the address by one, for as long as bytes arrive.
- R6: A burst read streams bytes from consecutive addresses with no gap. Each time a byte starts shifting out, a `reg_rd` for the following address is issued, so a burst of N complete bytes produces N+2 read strobes. The serial clock must stay at each level for at least 4 system clocks.
- R7: The burst address wraps from 3FFFh to 0000h and keeps counting.
- R8: Chip select high at any time returns the block to waiting for a control word. A data byte whose eighth bit has not been sampled is never written.
- R9: `sdo_oe` is low at all times except while read data is being shifted out. While enabled, `sdo` changes only on a detected falling serial-clock edge.
- R10: `reg_wr` and `reg_rd` are single-cycle pulses and never active together. A `reg_wr` follows the rising serial-clock edge that completed its byte by one system clock.
- R11: During and directly after reset, `sdo_oe`, `reg_wr` and `reg_rd` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lsb_first | input | 1 | Static bit-order select (1 = LSB first) |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data from master |
| sdo | output | 1 | Serial data to master |
| sdo_oe | output | 1 | Output enable for the external buffer on `sdo` |
| reg_addr | output | 14 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, valid one clock after `reg_rd` |

## Verification
The hardest situations to reach are a chip-select rise a few bits into a burst byte, and bursts whose address range crosses 3FFFh. A random master hits them rarely. The stimulus therefore mixes directed transactions with random ones. The directed cases start bursts just below the top of the space, abort inside the control word, and abort inside a data byte. The random cases draw addresses biased toward the top of the space and append random partial bytes before chip select rises. Single-byte reads and writes also get extra clock bits, to show that the surplus bytes neither write nor keep the output enabled.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [1:0] {
    PH_CTRL  = 2'd0,
    PH_WDATA = 2'd1,
    PH_RDATA = 2'd2,
    PH_DONE  = 2'd3
  } spi_phase_e;

endpackage

// File: rtl/spi_sclk_edges.sv
module spi_sclk_edges (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  output logic rise,
  output logic fall
);

  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q_next
);

  logic [W-2:0] hist;

  assign q_next = {hist, din};

  always_ff @(posedge clk) begin
    if (rst || clr) hist <= '0;
    else if (en)    hist <= q_next[W-2:0];
  end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic         lsb_first,
  input  logic [W-1:0] din,
  output logic         dout
);

  logic [W-1:0] ordered;
  logic [W-1:0] sh;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      ordered[i] = lsb_first ? din[W-1-i] : din[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      dout <= 1'b0;
    end else if (load) begin
      dout <= ordered[W-1];
      sh   <= {ordered[W-2:0], 1'b0};
    end else if (shift) begin
      dout <= sh[W-1];
      sh   <= {sh[W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lsb_first,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int CTRL_W = ADDR_W + 2;
  localparam int CNT_W  = $clog2(CTRL_W);
  localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(CTRL_W - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);

  logic rise, fall;
  logic [CTRL_W-1:0] rx_nx;
  logic [ADDR_W-1:0] addr_field, addr_dec, addr_q;
  logic [DATA_W-1:0] data_raw, data_dec, pf_buf;
  logic [CNT_W-1:0]  cnt;
  logic              burst_q, sent_q, rd_wait;
  logic              tx_load, tx_shift;
  spi_phase_e        phase;

  spi_sclk_edges u_edges (
    .clk  (clk),
    .rst  (rst),
    .sclk (sclk),
    .rise (rise),
    .fall (fall)
  );

  spi_rx_shift #(.W(CTRL_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .clr    (cs_n),
    .en     (rise & ~cs_n),
    .din    (sdi),
    .q_next (rx_nx)
  );

  spi_tx_shift #(.W(DATA_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (tx_load),
    .shift     (tx_shift),
    .lsb_first (lsb_first),
    .din       (pf_buf),
    .dout      (sdo)
  );

  // Field decode from the shift value including the bit arriving now.
  always_comb begin
    addr_field = rx_nx[CTRL_W-2:1];
    data_raw   = rx_nx[DATA_W-1:0];
    for (int i = 0; i < ADDR_W; i++) begin
      addr_dec[i] = lsb_first ? addr_field[ADDR_W-1-i] : addr_field[i];
    end
    for (int i = 0; i < DATA_W; i++) begin
      data_dec[i] = lsb_first ? data_raw[DATA_W-1-i] : data_raw[i];
    end
  end

  // Transmit control: load a prefetched byte at a byte boundary, else shift.
  always_comb begin
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    if (!cs_n && fall && phase == PH_RDATA) begin
      if (cnt == '0) tx_load  = burst_q || !sent_q;
      else           tx_shift = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    reg_wr  <= 1'b0;
    reg_rd  <= 1'b0;
    rd_wait <= reg_rd;
    if (rd_wait) pf_buf <= reg_rdata;
    if (rst) begin
      phase     <= PH_CTRL;
      cnt       <= '0;
      burst_q   <= 1'b0;
      sent_q    <= 1'b0;
      addr_q    <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      sdo_oe    <= 1'b0;
      pf_buf    <= '0;
      rd_wait   <= 1'b0;
    end else if (cs_n) begin
      phase   <= PH_CTRL;
      cnt     <= '0;
      burst_q <= 1'b0;
      sent_q  <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      case (phase)
        PH_CTRL: begin
          if (rise) begin
            if (cnt == CTRL_LAST) begin
              cnt     <= '0;
              burst_q <= rx_nx[0];
              addr_q  <= addr_dec;
              if (rx_nx[CTRL_W-1]) begin
                phase    <= PH_RDATA;
                reg_rd   <= 1'b1;
                reg_addr <= addr_dec;
              end else begin
                phase <= PH_WDATA;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_WDATA: begin
          if (rise) begin
            if (cnt == BYTE_LAST) begin
              cnt       <= '0;
              reg_wr    <= 1'b1;
              reg_wdata <= data_dec;
              reg_addr  <= addr_q;
              addr_q    <= addr_q + 1'b1;
              if (!burst_q) phase <= PH_DONE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_RDATA: begin
          if (fall) begin
            if (cnt == '0 && !burst_q && sent_q) begin
              sdo_oe <= 1'b0;
              phase  <= PH_DONE;
            end else begin
              cnt <= (cnt == BYTE_LAST) ? '0 : cnt + 1'b1;
              if (cnt == '0) begin
                sdo_oe <= 1'b1;
                sent_q <= 1'b1;
                if (burst_q) begin
                  reg_rd   <= 1'b1;
                  reg_addr <= addr_q + 1'b1;
                  addr_q   <= addr_q + 1'b1;
                end
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic sdo,
  input logic sdo_oe,
  input logic reg_wr,
  input logic reg_rd
);

  // R10: strobes are exclusive
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));

  // R10: write strobe lasts one cycle
  a_r10_wr_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  // R10: read strobe lasts one cycle
  a_r10_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);

  // R10 / R8: a write follows a rising serial edge seen with chip select low
  a_r10_wr_after_rise: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> ($past(sclk) && !$past(sclk, 2) && !$past(cs_n)));

  // R9 / R8: chip select high releases the output
  a_r9_oe_off_when_idle: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !sdo_oe);

  // R9: driven data changes only after a falling serial edge
  a_r9_sdo_on_fall: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe && $past(sdo_oe) && (sdo != $past(sdo))) |-> ($past(sclk, 2) && !$past(sclk)));

  // R11: reset leaves outputs quiet
  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!sdo_oe && !reg_wr && !reg_rd));

endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .cs_n   (cs_n),
  .sclk   (sclk),
  .sdo    (sdo),
  .sdo_oe (sdo_oe),
  .reg_wr (reg_wr),
  .reg_rd (reg_rd)
);

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lsb_first = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdo_oe;
  logic [13:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_rdata = 8'h00;

  spi_reg_slave dut (
    .clk       (clk),
    .rst       (rst),
    .lsb_first (lsb_first),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sdi       (sdi),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;
  logic [7:0] salt = 8'h5A;

  logic [13:0] wa [64];
  logic [7:0]  wd [64];
  int          wcnt = 0;
  int          rcnt = 0;
  logic [7:0]  tx_bytes [8];
  logic [7:0]  rx_bytes [8];

  function automatic logic [7:0] model_rd(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b01} ^ salt;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // register file model: data one clock after the read strobe
  always @(posedge clk) begin
    if (reg_rd) reg_rdata <= model_rd(reg_addr);
    if (reg_wr) begin
      wa[wcnt % 64] <= reg_addr;
      wd[wcnt % 64] <= reg_wdata;
      wcnt <= wcnt + 1;
    end
    if (reg_rd) rcnt <= rcnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic o, output logic oe);
    sdi = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    o  = sdo;
    oe = sdo_oe;
    repeat (HALF-2) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic run_txn(input bit rw, input logic [13:0] a, input bit burst,
                         input int nb, input int extra);
    logic [15:0] w;
    logic [13:0] af;
    logic [7:0]  d, r;
    logic        o, oe;
    int          w0, r0, exp_w, exp_r;
    w0 = wcnt;
    r0 = rcnt;
    for (int i = 0; i < 14; i++) af[i] = lsb_first ? a[13-i] : a[i];
    w = {rw, af, burst};
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      bitx(w[i], o, oe);
      chk(oe == 1'b0, "R9", "oe during control word", int'(oe), 0);
    end
    for (int k = 0; k < nb; k++) begin
      d = lsb_first ? rev8(tx_bytes[k]) : tx_bytes[k];
      r = '0;
      for (int i = 7; i >= 0; i--) begin
        bitx(rw ? 1'b0 : d[i], o, oe);
        r = {r[6:0], o};
        if (!rw || (!burst && k > 0))
          chk(oe == 1'b0, rw ? "R4" : "R9", "oe not reading", int'(oe), 0);
        else
          chk(oe == 1'b1, "R9", "oe while reading", int'(oe), 1);
      end
      rx_bytes[k] = lsb_first ? rev8(r) : r;
    end
    for (int i = 0; i < extra; i++) begin
      bitx(rw ? 1'b0 : 1'($urandom), o, oe);
      if (!rw || !burst)
        chk(oe == 1'b0, "R9", "oe in trailing bits", int'(oe), 0);
    end
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(sdo_oe == 1'b0, "R8", "oe after chip select high", int'(sdo_oe), 0);
    if (!rw) begin
      exp_w = burst ? nb : (nb > 0 ? 1 : 0);
      chk(wcnt - w0 == exp_w, burst ? (extra > 0 ? "R8" : "R5") : "R3",
          "write count", wcnt - w0, exp_w);
      for (int k = 0; k < exp_w && k < wcnt - w0; k++) begin
        chk(wa[(w0+k) % 64] == 14'(a + 14'(k)), (a > 14'h3FF8) ? "R7" : "R5",
            "write address", int'(wa[(w0+k) % 64]), int'(14'(a + 14'(k))));
        chk(wd[(w0+k) % 64] == tx_bytes[k], lsb_first ? "R2" : "R1",
            "write data", int'(wd[(w0+k) % 64]), int'(tx_bytes[k]));
      end
    end else begin
      exp_r = burst ? nb + 2 : 1;
      chk(rcnt - r0 == exp_r, burst ? "R6" : "R4", "read strobe count",
          rcnt - r0, exp_r);
      for (int k = 0; k < (burst ? nb : (nb > 0 ? 1 : 0)); k++) begin
        chk(rx_bytes[k] == model_rd(14'(a + 14'(k))),
            (a > 14'h3FF8) ? "R7" : (lsb_first ? "R2" : "R6"),
            "read data", int'(rx_bytes[k]), int'(model_rd(14'(a + 14'(k)))));
      end
    end
  endtask

  task automatic abort_ctrl(input int nbits);
    logic o, oe;
    int   w0;
    w0 = wcnt;
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) bitx(1'b0, o, oe);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(wcnt == w0, "R8", "write after control abort", wcnt - w0, 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog expired: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(sdo_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R11",
        "outputs in reset", int'({sdo_oe, reg_wr, reg_rd}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sdo_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R11",
        "outputs after reset", int'({sdo_oe, reg_wr, reg_rd}), 0);

    // R1/R3: single write with a surplus byte that must be ignored
    tx_bytes[0] = 8'hC3; tx_bytes[1] = 8'h7E;
    run_txn(1'b0, 14'h1234, 1'b0, 2, 0);
    // R4: single read with surplus clocks
    run_txn(1'b1, 14'h0ABC, 1'b0, 2, 3);
    // R5/R7: burst write across the top of the space
    for (int k = 0; k < 8; k++) tx_bytes[k] = 8'(8'h11 * (k + 1));
    run_txn(1'b0, 14'h3FFE, 1'b1, 4, 0);
    // R6/R7: burst read across the top, MSB first
    run_txn(1'b1, 14'h3FFD, 1'b1, 5, 0);
    // R2: LSB-first write and burst read
    lsb_first = 1'b1;
    tx_bytes[0] = 8'h01;
    run_txn(1'b0, 14'h0001, 1'b0, 1, 0);
    salt = 8'hA5;
    run_txn(1'b1, 14'h2003, 1'b1, 3, 0);
    lsb_first = 1'b0;
    // R8: abort inside a data byte and inside the control word
    run_txn(1'b0, 14'h0100, 1'b1, 1, 7);
    abort_ctrl(9);
    tx_bytes[0] = 8'h99;
    run_txn(1'b0, 14'h0200, 1'b0, 1, 0);

    for (int t = 0; t < 40; t++) begin
      logic [13:0] a;
      bit rw, bu;
      int nb, ex;
      rw = 1'($urandom);
      bu = 1'($urandom);
      a  = ($urandom % 4 == 0) ? 14'(14'h3FFF - 14'($urandom % 4)) : 14'($urandom);
      nb = bu ? 1 + int'($urandom % 5) : 1;
      ex = ($urandom % 3 == 0) ? int'($urandom % 8) : 0;
      lsb_first = 1'($urandom);
      salt = 8'($urandom);
      for (int k = 0; k < 8; k++) tx_bytes[k] = 8'($urandom);
      run_txn(rw, a, bu, nb, ex);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule